// File: doc/BRIEF.md
# Serial Debug Command Decoder with Register Burst Engine

This block sits behind a one-bit-per-cycle debug link and turns the bit stream into actions on a CPU debug port. A frame is opened with a one-cycle `frameStart` pulse. The bits that follow are consumed one per cycle while `linkValid` is high. The first frame after reset, and every frame that is not a burst, is a command frame.

A command frame opens with a leading zero and a 4-bit opcode. The opcode does one of three things. It can prepare a burst of CPU register reads or writes, with a start address and a word count. It can write the two-bit control register that drives the CPU stall and reset lines. Or it can choose which internal register is shifted back to the host.

The frame that follows a burst setup carries only data. Each 32-bit word moves across the CPU port, and the register address steps by one after every word. The burst ends with a CRC-32 exchange. On a write burst the block reports whether the host CRC matched the one it computed.

Every field is sent least significant bit first. While a command frame is being received, `linkOut` returns the selected internal register, starting with the frame's first bit.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset, `cpuStall` and `cpuReset` are 0, `cpuWrEn` and `cpuRdEn` are 0, the selected index is 0, and the first frame is a command frame.
- R2: A command frame starts with one leading bit and then the 4-bit opcode. If the leading bit is 1, the rest of the frame is ignored.
- R3: Opcode 0x9 is followed by an IDX_W-bit index and then 2 data bits. Data bit 0 drives `cpuStall` and bit 1 drives `cpuReset`. Only index 0 changes them.
- R4: Opcode 0xD is followed by an IDX_W-bit index, which becomes the selected index. In every command frame, `linkOut` shifts out the selected register, LSB first, from the first bit onward: the 2-bit control register for index 0, and zeros for any other index.
- R5: Opcode 0x0 (NOP) and every opcode other than 0x3, 0x7, 0x9 and 0xD change neither the control register nor the selection. The rest of such a frame is ignored.
- R6: Opcode 0x3 (write) or 0x7 (read) is followed by a 16-bit address and then a 16-bit count. With a nonzero count, the next frame is a burst frame. With a zero count, it is a command frame. The frame after a burst frame is always a command frame.
- R7: In a write burst frame, 0 bits are skipped until a 1 start bit arrives. Then `count` words of 32 bits each follow. Each word is presented with a one-cycle `cpuWrEn`, in the cycle after its last bit, at address start+k (modulo 2^16).
- R8: After the last write word, the status slot outputs 1. The host then sends 32 CRC bits. In the following match slot, `linkOut` is 1 exactly when they equal the local CRC. A mismatch does not withdraw words already written.
- R9: In a read burst frame, the first slot outputs 1 and raises `cpuRdEn` to fetch the word at the start address. Each word is then shifted out LSB first. The next word is fetched, with `cpuRdEn`, during the last bit of the previous word, at address start+k.
- R10: After the last read word, the 32-bit local CRC is shifted out LSB first.
- R11: The CRC starts at 0xFFFFFFFF at each frame start. Per data bit b in transfer order, it is shifted left once and XORed with 0x04C11DB7 when (crc[31] xor b) is 1. There is no final inversion.
- R12: `cpuWrEn` and `cpuRdEn` are never high together. `cpuAddr` advances by exactly one after each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse that opens a new frame |
| linkValid | input | 1 | `linkBit` is consumed this cycle |
| linkBit | input | 1 | Serial input bit |
| linkOut | output | 1 | Serial output bit for the current slot |
| cpuAddr | output | ADDR_W | CPU register address |
| cpuWrData | output | 32 | CPU register write data |
| cpuWrEn | output | 1 | CPU register write strobe |
| cpuRdEn | output | 1 | CPU register read strobe (data taken this cycle) |
| cpuRdData | input | 32 | CPU register read data for `cpuAddr` |
| cpuStall | output | 1 | Stall request, control bit 0 |
| cpuReset | output | 1 | Reset request, control bit 1 |

## Verification
The bench sweeps every opcode after a known control value. A decoder that let an unlisted opcode fall through to the write or setup path would alter the control lines or start a burst. It also sweeps every index/data pair of the control-register write. A design that ignored the index would change the stall and reset lines for a nonzero index.

Bursts are run from address 0xFFFF and 0xFFFE, where a wrong address width or a missed increment shows up as a wrong address after wraparound. A zero-count setup is checked to leave the next frame a command frame. One write burst carries a corrupted CRC: the match slot must drop to 0, while the words already written must remain logged. The read CRC is recomputed bit by bit, so a CRC that was updated with the wrong bit or one cycle late would not match.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam logic [3:0] OP_NOP  = 4'h0;
  localparam logic [3:0] OP_BWR  = 4'h3;
  localparam logic [3:0] OP_BRD  = 4'h7;
  localparam logic [3:0] OP_IWR  = 4'h9;
  localparam logic [3:0] OP_ISEL = 4'hD;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [3:0] {
    ST_HEAD, ST_OPC, ST_ADDR, ST_CNT, ST_WIDX, ST_WDAT, ST_SIDX, ST_SKIP,
    ST_WSTART, ST_WDATA, ST_WSTAT, ST_WCRC, ST_WMATCH,
    ST_RSTAT, ST_RDATA, ST_RCRC
  } stateT;

  // control -> datapath strobes
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadStat;
    logic loadAddr;
    logic loadCnt;
    logic loadIdx;
    logic writeIreg;
    logic selIreg;
    logic crcInit;
    logic crcUpd;
    logic crcFromOut;
    logic commitWr;
    logic fetchRd;
    logic loadCrc;
    logic decCnt;
    logic checkCrc;
  } strobeT;

endpackage

// File: rtl/dbg_cmd_dp.sv
module dbg_cmd_dp
  import dbg_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              linkBit,
  input  logic [31:0]       cpuRdData,
  output logic [3:0]        opField,
  output logic              cntFieldZero,
  output logic              lastWord,
  output logic              outBit,
  output logic              matchOk,
  output logic [ADDR_W-1:0] cpuAddr,
  output logic [31:0]       cpuWrData,
  output logic              cpuWrEn,
  output logic [1:0]        ctrlReg
);

  logic [31:0]       inShift, outShift, crcReg, wrDataReg;
  logic [31:0]       nxtIn, crcNxt;
  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [IDX_W-1:0]  idxTmp, selIdx;
  logic [1:0]        statReg;
  logic              wrEnReg, matchReg, crcBit;

  assign nxtIn        = {linkBit, inShift[31:1]};
  assign opField      = nxtIn[31:28];
  assign cntFieldZero = (nxtIn[31 -: CNT_W] == '0);
  assign lastWord     = (cntReg == CNT_W'(1));
  assign crcBit       = strb.crcFromOut ? outShift[0] : linkBit;
  assign crcNxt       = {crcReg[30:0], 1'b0} ^ ({32{crcReg[31] ^ crcBit}} & CRC_POLY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift   <= '0;
      outShift  <= '0;
      crcReg    <= '1;
      wrDataReg <= '0;
      addrReg   <= '0;
      cntReg    <= '0;
      idxTmp    <= '0;
      selIdx    <= '0;
      statReg   <= '0;
      wrEnReg   <= 1'b0;
      matchReg  <= 1'b0;
    end else begin
      if (strb.shiftIn) inShift <= nxtIn;

      if (strb.loadStat)      outShift <= (selIdx == '0) ? {30'd0, statReg} : '0;
      else if (strb.fetchRd)  outShift <= cpuRdData;
      else if (strb.loadCrc)  outShift <= crcNxt;
      else if (strb.shiftOut) outShift <= {1'b0, outShift[31:1]};

      if (strb.loadAddr)                addrReg <= nxtIn[31 -: ADDR_W];
      else if (strb.fetchRd || wrEnReg) addrReg <= addrReg + 1'b1;

      if (strb.loadCnt)     cntReg <= nxtIn[31 -: CNT_W];
      else if (strb.decCnt) cntReg <= cntReg - 1'b1;

      if (strb.loadIdx) idxTmp <= nxtIn[31 -: IDX_W];
      if (strb.selIreg) selIdx <= nxtIn[31 -: IDX_W];
      if (strb.writeIreg && idxTmp == '0) statReg <= nxtIn[31:30];

      if (strb.crcInit)     crcReg <= '1;
      else if (strb.crcUpd) crcReg <= crcNxt;

      wrEnReg <= strb.commitWr;
      if (strb.commitWr) wrDataReg <= nxtIn;

      if (strb.crcInit)       matchReg <= 1'b0;
      else if (strb.checkCrc) matchReg <= (nxtIn == crcReg);
    end
  end

  assign outBit    = outShift[0];
  assign matchOk   = matchReg;
  assign cpuAddr   = addrReg;
  assign cpuWrData = wrDataReg;
  assign cpuWrEn   = wrEnReg;
  assign ctrlReg   = statReg;

endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       linkValid,
  input  logic       linkBit,
  input  logic [3:0] opField,
  input  logic       cntFieldZero,
  input  logic       lastWord,
  input  logic       outBit,
  input  logic       matchOk,
  output strobeT     strb,
  output logic       linkOut
);

  localparam logic [4:0] ADDR_LAST = 5'(ADDR_W - 1);
  localparam logic [4:0] CNT_LAST  = 5'(CNT_W - 1);
  localparam logic [4:0] IDX_LAST  = 5'(IDX_W - 1);
  localparam logic [4:0] WORD_LAST = 5'd31;

  stateT      state, nState;
  logic [4:0] bitCnt;
  logic [3:0] opReg;
  logic       armWr, armRd;

  always_comb begin
    strb   = '0;
    nState = state;
    if (frameStart) begin
      strb.loadStat = 1'b1;
      strb.crcInit  = 1'b1;
      nState = armWr ? ST_WSTART : (armRd ? ST_RSTAT : ST_HEAD);
    end else if (linkValid) begin
      unique case (state)
        ST_HEAD: begin
          strb.shiftOut = 1'b1;
          nState = linkBit ? ST_SKIP : ST_OPC;
        end
        ST_OPC: begin
          strb.shiftIn  = 1'b1;
          strb.shiftOut = 1'b1;
          if (bitCnt == 5'd3) begin
            unique case (opField)
              OP_BWR, OP_BRD: nState = ST_ADDR;
              OP_IWR:         nState = ST_WIDX;
              OP_ISEL:        nState = ST_SIDX;
              default:        nState = ST_SKIP;
            endcase
          end
        end
        ST_ADDR: begin
          strb.shiftIn  = 1'b1;
          strb.shiftOut = 1'b1;
          if (bitCnt == ADDR_LAST) begin
            strb.loadAddr = 1'b1;
            nState = ST_CNT;
          end
        end
        ST_CNT: begin
          strb.shiftIn  = 1'b1;
          strb.shiftOut = 1'b1;
          if (bitCnt == CNT_LAST) begin
            strb.loadCnt = 1'b1;
            nState = ST_SKIP;
          end
        end
        ST_WIDX: begin
          strb.shiftIn  = 1'b1;
          strb.shiftOut = 1'b1;
          if (bitCnt == IDX_LAST) begin
            strb.loadIdx = 1'b1;
            nState = ST_WDAT;
          end
        end
        ST_WDAT: begin
          strb.shiftIn  = 1'b1;
          strb.shiftOut = 1'b1;
          if (bitCnt == 5'd1) begin
            strb.writeIreg = 1'b1;
            nState = ST_SKIP;
          end
        end
        ST_SIDX: begin
          strb.shiftIn  = 1'b1;
          strb.shiftOut = 1'b1;
          if (bitCnt == IDX_LAST) begin
            strb.selIreg = 1'b1;
            nState = ST_SKIP;
          end
        end
        ST_SKIP: strb.shiftOut = 1'b1;
        ST_WSTART: if (linkBit) nState = ST_WDATA;
        ST_WDATA: begin
          strb.shiftIn = 1'b1;
          strb.crcUpd  = 1'b1;
          if (bitCnt == WORD_LAST) begin
            strb.commitWr = 1'b1;
            strb.decCnt   = 1'b1;
            if (lastWord) nState = ST_WSTAT;
          end
        end
        ST_WSTAT: nState = ST_WCRC;
        ST_WCRC: begin
          strb.shiftIn = 1'b1;
          if (bitCnt == WORD_LAST) begin
            strb.checkCrc = 1'b1;
            nState = ST_WMATCH;
          end
        end
        ST_WMATCH: nState = ST_SKIP;
        ST_RSTAT: begin
          strb.fetchRd = 1'b1;
          nState = ST_RDATA;
        end
        ST_RDATA: begin
          strb.crcUpd     = 1'b1;
          strb.crcFromOut = 1'b1;
          if (bitCnt == WORD_LAST) begin
            strb.decCnt = 1'b1;
            if (lastWord) begin
              strb.loadCrc = 1'b1;
              nState = ST_RCRC;
            end else begin
              strb.fetchRd = 1'b1;
            end
          end else begin
            strb.shiftOut = 1'b1;
          end
        end
        ST_RCRC: begin
          strb.shiftOut = 1'b1;
          if (bitCnt == WORD_LAST) nState = ST_SKIP;
        end
        default: nState = ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_SKIP;
      bitCnt <= '0;
      opReg  <= OP_NOP;
      armWr  <= 1'b0;
      armRd  <= 1'b0;
    end else begin
      state <= nState;
      if (frameStart || (linkValid && nState != state)) bitCnt <= '0;
      else if (linkValid) bitCnt <= bitCnt + 1'b1;

      if (frameStart) begin
        armWr <= 1'b0;
        armRd <= 1'b0;
      end else if (linkValid && state == ST_CNT && bitCnt == CNT_LAST && !cntFieldZero) begin
        armWr <= (opReg == OP_BWR);
        armRd <= (opReg == OP_BRD);
      end

      if (linkValid && !frameStart && state == ST_OPC && bitCnt == 5'd3) opReg <= opField;
    end
  end

  always_comb begin
    unique case (state)
      ST_RSTAT, ST_WSTAT:           linkOut = 1'b1;
      ST_WMATCH:                    linkOut = matchOk;
      ST_WSTART, ST_WDATA, ST_WCRC: linkOut = 1'b0;
      default:                      linkOut = outBit;
    endcase
  end

endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
  import dbg_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              linkValid,
  input  logic              linkBit,
  output logic              linkOut,
  output logic [ADDR_W-1:0] cpuAddr,
  output logic [31:0]       cpuWrData,
  output logic              cpuWrEn,
  output logic              cpuRdEn,
  input  logic [31:0]       cpuRdData,
  output logic              cpuStall,
  output logic              cpuReset
);

  strobeT     strb;
  logic [3:0] opField;
  logic       cntFieldZero, lastWord, outBit, matchOk;
  logic [1:0] ctrlReg;

  dbg_cmd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .linkValid(linkValid),
    .linkBit(linkBit), .opField(opField), .cntFieldZero(cntFieldZero),
    .lastWord(lastWord), .outBit(outBit), .matchOk(matchOk),
    .strb(strb), .linkOut(linkOut)
  );

  dbg_cmd_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .linkBit(linkBit), .cpuRdData(cpuRdData),
    .opField(opField), .cntFieldZero(cntFieldZero), .lastWord(lastWord),
    .outBit(outBit), .matchOk(matchOk), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .ctrlReg(ctrlReg)
  );

  assign cpuRdEn  = strb.fetchRd;
  assign cpuStall = ctrlReg[0];
  assign cpuReset = ctrlReg[1];

endmodule

// File: rtl/dbg_cmd_chk.sv
module dbg_cmd_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              linkValid,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuWrEn,
  input logic              cpuRdEn,
  input logic              cpuStall,
  input logic              cpuReset
);

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWrEn && cpuRdEn));

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> !cpuWrEn);

  // R12
  wr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> cpuAddr == ADDR_W'($past(cpuAddr) + 1'b1));

  // R12
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdEn |=> cpuAddr == ADDR_W'($past(cpuAddr) + 1'b1));

  // R9
  rd_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdEn |-> linkValid);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkValid |=> $stable({cpuReset, cpuStall}));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!linkValid && !cpuWrEn) |=> $stable(cpuAddr));

endmodule

bind dbg_cmd_decoder dbg_cmd_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .linkValid(linkValid), .cpuAddr(cpuAddr),
  .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuStall(cpuStall), .cpuReset(cpuReset)
);

// File: tb/test_dbg_cmd_decoder.sv
`timescale 1ns/1ps
module test_dbg_cmd_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0, linkValid = 1'b0, linkBit = 1'b0;
  logic        linkOut, cpuWrEn, cpuRdEn, cpuStall, cpuReset;
  logic [15:0] cpuAddr;
  logic [31:0] cpuWrData, cpuRdData;

  int total = 0, bad = 0, wrN = 0;
  logic [15:0] wrAddr [16];
  logic [31:0] wrData [16];
  logic rdSeen;
  logic [15:0] addrSeen;
  logic [1:0]  ctrlExp;

  always #2.5 clk = ~clk;

  dbg_cmd_decoder i_dbg_cmd_decoder (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .linkValid(linkValid),
    .linkBit(linkBit), .linkOut(linkOut), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData),
    .cpuStall(cpuStall), .cpuReset(cpuReset)
  );

  function automatic logic [31:0] regModel(input logic [15:0] a);
    return {a ^ 16'hA5C3, a + 16'h1234};
  endfunction

  assign cpuRdData = regModel(cpuAddr);

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? 32'h04C11DB7 : 32'h0);
  endfunction

  function automatic logic [31:0] wordGen(input int k, input logic [31:0] seed);
    return (32'h9E3779B9 * (k + 1)) ^ seed;
  endfunction

  always @(negedge clk) begin
    if (rstN && cpuWrEn) begin
      if (wrN < 16) begin
        wrAddr[wrN] = cpuAddr;
        wrData[wrN] = cpuWrData;
      end
      wrN++;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic got);
    @(negedge clk);
    frameStart = 1'b0;
    linkValid  = 1'b1;
    linkBit    = b;
    #1;
    got      = linkOut;
    rdSeen   = cpuRdEn;
    addrSeen = cpuAddr;
  endtask

  task automatic sendBits(input logic [63:0] v, input int n, output logic [63:0] o);
    logic g;
    o = '0;
    for (int i = 0; i < n; i++) begin
      sendBit(v[i], g);
      o[i] = g;
    end
  endtask

  task automatic frame();
    @(negedge clk);
    linkValid  = 1'b0;
    frameStart = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      linkValid  = 1'b0;
      frameStart = 1'b0;
    end
  endtask

  task automatic readSel(output logic [1:0] r);
    logic [63:0] o;
    frame();
    sendBits(64'h0, 5, o);
    idle(1);
    r = o[1:0];
  endtask

  task automatic writeCtrl(input logic [1:0] idx, input logic [1:0] d);
    logic [63:0] o;
    frame();
    sendBits({55'd0, d, idx, 4'h9, 1'b0}, 9, o);
    idle(1);
  endtask

  task automatic selectIdx(input logic [1:0] idx);
    logic [63:0] o;
    frame();
    sendBits({57'd0, idx, 4'hD, 1'b0}, 7, o);
    idle(1);
  endtask

  task automatic setup(input logic [3:0] op, input logic [15:0] a, input logic [15:0] c);
    logic [63:0] o;
    frame();
    sendBits({27'd0, c, a, op, 1'b0}, 37, o);
    idle(1);
  endtask

  task automatic burstWrite(input logic [15:0] a, input int cnt, input logic [31:0] seed,
                            input logic corrupt);
    logic g;
    logic [31:0] crc, w;
    logic [63:0] o;
    setup(4'h3, a, 16'(cnt));
    frame();
    wrN = 0;
    sendBit(1'b0, g);
    sendBit(1'b0, g);
    sendBit(1'b1, g);
    crc = 32'hFFFFFFFF;
    for (int k = 0; k < cnt; k++) begin
      w = wordGen(k, seed);
      for (int i = 0; i < 32; i++) begin
        sendBit(w[i], g);
        crc = crcStep(crc, w[i]);
      end
    end
    sendBit(1'b0, g);
    check("R8 write status slot", 32'(g), 32'd1);
    sendBits({32'd0, crc ^ {31'd0, corrupt}}, 32, o);
    sendBit(1'b0, g);
    check("R8 R11 match slot", 32'(g), 32'(!corrupt));
    idle(2);
    check("R7 write count", 32'(wrN), 32'(cnt));
    for (int k = 0; k < cnt && k < 16; k++) begin
      check("R7 write address", 32'(wrAddr[k]), 32'(16'(a + 16'(k))));
      check("R7 write data", wrData[k], wordGen(k, seed));
    end
  endtask

  task automatic burstRead(input logic [15:0] a, input int cnt);
    logic g;
    logic [31:0] crc, w, got;
    setup(4'h7, a, 16'(cnt));
    frame();
    sendBit(1'b0, g);
    check("R9 read status slot", 32'(g), 32'd1);
    check("R9 first fetch strobe", 32'(rdSeen), 32'd1);
    check("R9 first fetch address", 32'(addrSeen), 32'(a));
    crc = 32'hFFFFFFFF;
    for (int k = 0; k < cnt; k++) begin
      w = regModel(16'(a + 16'(k)));
      for (int i = 0; i < 32; i++) begin
        sendBit(1'b0, g);
        got[i] = g;
        crc = crcStep(crc, w[i]);
        if (i == 31 && k < cnt - 1) begin
          check("R9 next fetch strobe", 32'(rdSeen), 32'd1);
          check("R9 next fetch address", 32'(addrSeen), 32'(16'(a + 16'(k + 1))));
        end
      end
      check("R9 read word", got, w);
    end
    for (int i = 0; i < 32; i++) begin
      sendBit(1'b0, g);
      got[i] = g;
    end
    check("R10 R11 read crc", got, crc);
    idle(2);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0]  r;
    logic [63:0] o;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    check("R1 stall", 32'(cpuStall), 32'd0);
    check("R1 reset", 32'(cpuReset), 32'd0);
    check("R1 strobes", {30'd0, cpuWrEn, cpuRdEn}, 32'd0);
    readSel(r);
    check("R1 readout", 32'(r), 32'd0);

    // R3: sweep index and data of the control write
    ctrlExp = 2'b00;
    for (int idx = 0; idx < 4; idx++) begin
      for (int d = 0; d < 4; d++) begin
        writeCtrl(2'(idx), 2'(d));
        if (idx == 0) ctrlExp = 2'(d);
        check("R3 control lines", {30'd0, cpuReset, cpuStall}, 32'(ctrlExp));
        readSel(r);
        check("R4 readout index0", 32'(r), 32'(ctrlExp));
      end
    end

    // R4: select nonzero -> zeros, back to 0 -> control
    writeCtrl(2'd0, 2'b10);
    ctrlExp = 2'b10;
    for (int idx = 1; idx < 4; idx++) begin
      selectIdx(2'(idx));
      readSel(r);
      check("R4 readout other index", 32'(r), 32'd0);
    end
    selectIdx(2'd0);
    readSel(r);
    check("R4 readout back to 0", 32'(r), 32'(ctrlExp));

    // R5: every opcode other than the four decoded ones
    wrN = 0;
    for (int op = 0; op < 16; op++) begin
      if (op == 3 || op == 7 || op == 9 || op == 13) continue;
      frame();
      sendBits({27'h7FFFFFF, 32'h0, 4'(op), 1'b0}, 37, o);
      idle(1);
      readSel(r);
      check("R5 ignored opcode", 32'(r), 32'(ctrlExp));
      frame();
      sendBits({55'd0, 2'b01, 2'b00, 4'h9, 1'b0}, 9, o);
      idle(1);
      ctrlExp = 2'b01;
      check("R5 next frame is command", {30'd0, cpuReset, cpuStall}, 32'(ctrlExp));
      writeCtrl(2'd0, 2'b10);
      ctrlExp = 2'b10;
    end
    check("R5 no cpu writes", 32'(wrN), 32'd0);

    // R2: leading 1 ignores the frame
    frame();
    sendBits({55'd0, 2'b01, 2'b00, 4'h9, 1'b1}, 9, o);
    idle(1);
    check("R2 leading one ignored", {30'd0, cpuReset, cpuStall}, 32'(ctrlExp));

    // R6: zero count leaves the next frame a command frame
    setup(4'h3, 16'h0040, 16'd0);
    writeCtrl(2'd0, 2'b01);
    ctrlExp = 2'b01;
    check("R6 zero count", {30'd0, cpuReset, cpuStall}, 32'(ctrlExp));

    // R7 R8: write bursts, including wrap and CRC mismatch
    burstWrite(16'h0010, 1, 32'h0BADF00D, 1'b0);
    burstWrite(16'hFFFF, 3, 32'h13579BDF, 1'b0);
    burstWrite(16'h2000, 2, 32'hCAFE1234, 1'b1);

    // R9 R10: read bursts, including wrap
    burstRead(16'h1234, 1);
    burstRead(16'hFFFE, 3);

    // R6: frame after a burst is a command frame
    writeCtrl(2'd0, 2'b11);
    check("R6 command after burst", {30'd0, cpuReset, cpuStall}, 32'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule